// File: doc/BRIEF.md
# Character I/O and Interrupt Entry Unit

This block serves a 16-bit accumulator machine with one input character channel, one output character channel and a single-level program interrupt. It keeps the received character and its "full" flag, the character to send and its "empty" flag, the interrupt enable, and the flag that marks an interrupt cycle. The surrounding control path passes in the current timing step and the instruction word. The block returns the strobes that the accumulator, the program counter, the address and temporary registers, memory and the sequence counter need.

Two pieces of behaviour live here. The first is the I/O instruction class: the top four instruction bits all ones, executed at timing step 3. Each low-order control bit in that class selects one action, and several may be set together. The second is the interrupt entry. When interrupts are enabled and a channel flag is raised, the block marks an interrupt cycle at the end of an instruction. The next three timing steps then replace the fetch. They save the program counter at word 0, continue at word 1 and mask further interrupts, so the service routine can return with an indirect branch through word 0.

The device side of each channel is a valid/ready pair. A character is written when the device raises `dev_in_valid` while `dev_in_ready` is high. A pending output character is taken when the device raises `dev_out_ready` while `dev_out_valid` is high.

Top module: `io_irq_unit`

## Requirements
- R1: After reset, the input flag is clear (`dev_in_ready`=1), the output flag is set (`dev_out_valid`=0), the interrupt enable is off and `irq_cycle`=0.
- R2: A device write (`dev_in_valid` and `dev_in_ready` high at a clock edge) stores `dev_in_data` as the input character and sets the input flag, so `dev_in_ready` is 0 from the next cycle.
- R3: An I/O instruction with bit 11 set drives `acc_lo_ld`=1 with `acc_lo_data` equal to the stored input character, and it clears the input flag at that edge. If a device write lands on the same edge, the device write wins.
- R4: An I/O instruction with bit 10 set loads `acc_lo` into the output character and clears the output flag (`dev_out_valid`=1 next cycle, `dev_out_data` = the loaded value). A device read (`dev_out_ready` and `dev_out_valid` high) sets the flag again. The instruction wins if both land on the same edge.
- R5: An I/O instruction with bit 9 set raises `pc_inc` when the input flag is 1. Bit 8 raises it when the output flag is 1.
- R6: An I/O instruction with bit 7 set turns the interrupt enable on, and bit 6 turns it off. When both are set, off wins.
- R7: An instruction whose bits 15..12 are 4'hF, presented at timing step 3 while `irq_cycle`=0, asserts `sc_clr`. Any other instruction word causes no I/O action.
- R8: The I/O class has no effect at any timing step other than 3.
- R9: `irq_cycle` rises only at the edge that ends a cycle whose timing step is 3 or more, with the enable on and at least one channel flag set. It never rises out of steps 0 to 2.
- R10: With `irq_cycle`=1, step 0 asserts `ar_clr` and `tr_ld_pc`, step 1 asserts `mem_wr` and `pc_clr`, and step 2 asserts `pc_inc` and `sc_clr`. These five strobes stay low while `irq_cycle`=0.
- R11: At the end of the step-2 cycle of the entry sequence, both `irq_cycle` and the interrupt enable are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| t_step | input | 4 | Current timing step from the sequence counter |
| instr | input | 16 | Current instruction word |
| acc_lo | input | 8 | Low byte of the accumulator |
| dev_in_valid | input | 1 | Input device offers a character |
| dev_in_data | input | 8 | Character from the input device |
| dev_in_ready | output | 1 | Input register empty (input flag clear) |
| dev_out_valid | output | 1 | Output character pending (output flag clear) |
| dev_out_data | output | 8 | Pending output character |
| dev_out_ready | input | 1 | Output device takes the character |
| acc_lo_ld | output | 1 | Load accumulator low byte; the upper byte is kept |
| acc_lo_data | output | 8 | Value for the accumulator low byte |
| pc_inc | output | 1 | Increment the program counter (skip or entry) |
| pc_clr | output | 1 | Clear the program counter |
| ar_clr | output | 1 | Clear the address register |
| tr_ld_pc | output | 1 | Copy the program counter into the temporary register |
| mem_wr | output | 1 | Write the temporary register to memory at the address register |
| sc_clr | output | 1 | Clear the sequence counter |
| irq_cycle | output | 1 | Interrupt cycle flag |

## Verification
The bench builds the block with its default parameters: 8-bit characters, a 16-bit instruction word and a 4-bit timing step. With these values the exact control-bit positions, the step-3 execution slot and steps 4 to 15 are all in reach. A full entry sequence, started from a real ION followed by a raised output flag, is therefore run cycle by cycle. The vector table drives the I/O decode across steps and instruction classes. The directed tests cover the flag handshakes, the ION/IOF conflict and the rule that the interrupt flag is held off during steps 0 to 2.

// File: rtl/io_irq_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the character I/O and interrupt unit.
// Assumes the instruction format: class in bits 15..12, I/O control bits below.
package io_irq_pkg;
    localparam logic [3:0] IO_CLASS  = 4'hF;  // opcode all ones with I=1
    localparam int         EXEC_STEP = 3;     // timing step of I/O execution
    localparam int         BIT_INP   = 11;
    localparam int         BIT_OUT   = 10;
    localparam int         BIT_SKI   = 9;
    localparam int         BIT_SKO   = 8;
    localparam int         BIT_ION   = 7;
    localparam int         BIT_IOF   = 6;

    typedef struct packed {
        logic exec;
        logic inp;
        logic outp;
        logic ski;
        logic sko;
        logic ion;
        logic iof;
    } io_cmd_t;
endpackage

// File: rtl/io_instr_dec.sv
`timescale 1ns/1ps
// Decodes the I/O instruction class into one strobe per action.
// Assumes: the class is valid only at EXEC_STEP and never during an interrupt cycle.
module io_instr_dec
    import io_irq_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int T_W    = 4
) (
    input  logic [WORD_W-1:0] instr,
    input  logic [T_W-1:0]    t_step,
    input  logic              irq_cycle,
    output io_cmd_t           cmd
);
    localparam logic [T_W-1:0] STEP_X = T_W'(EXEC_STEP);

    logic unused_low_bits;
    assign unused_low_bits = ^instr[BIT_IOF-1:0];

    // Qualify the class, then split out each control bit.
    always_comb begin
        cmd.exec = !irq_cycle && (t_step == STEP_X) && (instr[WORD_W-1 -: 4] == IO_CLASS);
        cmd.inp  = cmd.exec && instr[BIT_INP];
        cmd.outp = cmd.exec && instr[BIT_OUT];
        cmd.ski  = cmd.exec && instr[BIT_SKI];
        cmd.sko  = cmd.exec && instr[BIT_SKO];
        cmd.ion  = cmd.exec && instr[BIT_ION];
        cmd.iof  = cmd.exec && instr[BIT_IOF];
    end
endmodule

// File: rtl/io_in_reg.sv
`timescale 1ns/1ps
// Input character register with its full flag.
// Assumes: a device write and an instruction read on the same edge leave the flag set.
module io_in_reg #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_valid,
    input  logic [CHAR_W-1:0] dev_data,
    input  logic              take,
    output logic              dev_ready,
    output logic              full,
    output logic [CHAR_W-1:0] data
);
    logic wr_fire;
    assign wr_fire   = dev_valid && !full;
    assign dev_ready = !full;

    // Capture device characters and track the full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
            full <= 1'b0;
        end else begin
            if (wr_fire) data <= dev_data;
            if (wr_fire)   full <= 1'b1;
            else if (take) full <= 1'b0;
        end
    end
endmodule

// File: rtl/io_out_reg.sv
`timescale 1ns/1ps
// Output character register with its empty flag (set means ready for a new char).
// Assumes: an instruction load wins over a device read on the same edge.
module io_out_reg #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CHAR_W-1:0] src,
    input  logic              dev_ready,
    output logic              dev_valid,
    output logic              empty,
    output logic [CHAR_W-1:0] data
);
    assign dev_valid = !empty;

    // Load characters from the accumulator and track the empty flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data  <= '0;
            empty <= 1'b1;
        end else if (load) begin
            data  <= src;
            empty <= 1'b0;
        end else if (dev_ready && !empty) begin
            empty <= 1'b1;
        end
    end
endmodule

// File: rtl/io_irq_seq.sv
`timescale 1ns/1ps
// Interrupt enable, interrupt-cycle flag and the three-step entry sequence.
// Assumes: the sequence counter advances one step per cycle and is cleared on sc_clr.
module io_irq_seq #(
    parameter int T_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [T_W-1:0] t_step,
    input  logic           ion,
    input  logic           iof,
    input  logic           in_full,
    input  logic           out_empty,
    output logic           irq_cycle,
    output logic           irq_en,
    output logic           ar_clr,
    output logic           tr_ld_pc,
    output logic           mem_wr,
    output logic           pc_clr,
    output logic           entry_inc,
    output logic           entry_done
);
    localparam logic [T_W-1:0] S0 = T_W'(0);
    localparam logic [T_W-1:0] S1 = T_W'(1);
    localparam logic [T_W-1:0] S2 = T_W'(2);
    localparam logic [T_W-1:0] S3 = T_W'(3);

    logic set_req;

    // Step strobes of the entry sequence.
    always_comb begin
        ar_clr     = irq_cycle && (t_step == S0);
        tr_ld_pc   = irq_cycle && (t_step == S0);
        mem_wr     = irq_cycle && (t_step == S1);
        pc_clr     = irq_cycle && (t_step == S1);
        entry_inc  = irq_cycle && (t_step == S2);
        entry_done = irq_cycle && (t_step == S2);
        set_req    = !irq_cycle && (t_step >= S3) && irq_en && (in_full || out_empty);
    end

    // Interrupt enable: cleared by entry or IOF (IOF beats ION).
    always_ff @(posedge clk) begin
        if (!rst_n)          irq_en <= 1'b0;
        else if (entry_done) irq_en <= 1'b0;
        else if (iof)        irq_en <= 1'b0;
        else if (ion)        irq_en <= 1'b1;
    end

    // Interrupt-cycle flag: raised outside the fetch steps, dropped at entry end.
    always_ff @(posedge clk) begin
        if (!rst_n)          irq_cycle <= 1'b0;
        else if (entry_done) irq_cycle <= 1'b0;
        else if (set_req)    irq_cycle <= 1'b1;
    end
endmodule

// File: rtl/io_irq_unit.sv
`timescale 1ns/1ps
// Top: character I/O channels, I/O instruction execution and interrupt entry.
// Assumes: the datapath applies the strobes in the same cycle they are driven.
module io_irq_unit
    import io_irq_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int WORD_W = 16,
    parameter int T_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [T_W-1:0]    t_step,
    input  logic [WORD_W-1:0] instr,
    input  logic [CHAR_W-1:0] acc_lo,
    input  logic              dev_in_valid,
    input  logic [CHAR_W-1:0] dev_in_data,
    output logic              dev_in_ready,
    output logic              dev_out_valid,
    output logic [CHAR_W-1:0] dev_out_data,
    input  logic              dev_out_ready,
    output logic              acc_lo_ld,
    output logic [CHAR_W-1:0] acc_lo_data,
    output logic              pc_inc,
    output logic              pc_clr,
    output logic              ar_clr,
    output logic              tr_ld_pc,
    output logic              mem_wr,
    output logic              sc_clr,
    output logic              irq_cycle
);
    io_cmd_t           cmd;
    logic              in_flag;
    logic              out_flag;
    logic              irq_en;
    logic              entry_inc;
    logic              entry_done;
    logic [CHAR_W-1:0] in_char;

    io_instr_dec #(.WORD_W(WORD_W), .T_W(T_W)) u_dec (
        .instr(instr), .t_step(t_step), .irq_cycle(irq_cycle), .cmd(cmd)
    );

    io_in_reg #(.CHAR_W(CHAR_W)) u_in (
        .clk(clk), .rst_n(rst_n), .dev_valid(dev_in_valid), .dev_data(dev_in_data),
        .take(cmd.inp), .dev_ready(dev_in_ready), .full(in_flag), .data(in_char)
    );

    io_out_reg #(.CHAR_W(CHAR_W)) u_out (
        .clk(clk), .rst_n(rst_n), .load(cmd.outp), .src(acc_lo),
        .dev_ready(dev_out_ready), .dev_valid(dev_out_valid), .empty(out_flag),
        .data(dev_out_data)
    );

    io_irq_seq #(.T_W(T_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .t_step(t_step), .ion(cmd.ion), .iof(cmd.iof),
        .in_full(in_flag), .out_empty(out_flag), .irq_cycle(irq_cycle), .irq_en(irq_en),
        .ar_clr(ar_clr), .tr_ld_pc(tr_ld_pc), .mem_wr(mem_wr), .pc_clr(pc_clr),
        .entry_inc(entry_inc), .entry_done(entry_done)
    );

    // Merge skip, entry and counter-clear requests for the datapath.
    always_comb begin
        acc_lo_ld   = cmd.inp;
        acc_lo_data = in_char;
        pc_inc      = (cmd.ski && in_flag) || (cmd.sko && out_flag) || entry_inc;
        sc_clr      = cmd.exec || entry_done;
    end
endmodule

// File: rtl/io_irq_chk.sv
`timescale 1ns/1ps
// Checker for io_irq_unit: temporal properties on flags and entry strobes.
module io_irq_chk #(
    parameter int WORD_W = 16,
    parameter int T_W    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [T_W-1:0]    t_step,
    input logic [WORD_W-1:0] instr,
    input logic              dev_in_valid,
    input logic              dev_in_ready,
    input logic              dev_out_valid,
    input logic              irq_cycle,
    input logic              irq_en,
    input logic              ar_clr,
    input logic              tr_ld_pc,
    input logic              mem_wr,
    input logic              pc_clr
);
    logic inp_now;
    logic dev_wr_now;
    assign inp_now    = !irq_cycle && (t_step == T_W'(3)) && (instr[WORD_W-1 -: 4] == 4'hF) && instr[11];
    assign dev_wr_now = dev_in_valid && dev_in_ready;

    a_r1_reset_state: assert property (@(posedge clk)
        $past(!rst_n) && rst_n |-> dev_in_ready && !dev_out_valid && !irq_cycle && !irq_en);

    a_r2_dev_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        dev_wr_now |=> !dev_in_ready);

    a_r3_inp_empties: assert property (@(posedge clk) disable iff (!rst_n)
        inp_now && !dev_wr_now |=> dev_in_ready);

    a_r9_irq_window: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_cycle ##1 irq_cycle |-> $past(t_step) >= T_W'(3) && $past(irq_en));

    a_r10_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_cycle |-> !(ar_clr || tr_ld_pc || mem_wr || pc_clr));

    a_r10_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ar_clr, mem_wr}));

    a_r11_entry_exit: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cycle && t_step == T_W'(2) |=> !irq_cycle && !irq_en);
endmodule

bind io_irq_unit io_irq_chk #(.WORD_W(WORD_W), .T_W(T_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .t_step(t_step), .instr(instr),
    .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready),
    .dev_out_valid(dev_out_valid), .irq_cycle(irq_cycle), .irq_en(irq_en),
    .ar_clr(ar_clr), .tr_ld_pc(tr_ld_pc), .mem_wr(mem_wr), .pc_clr(pc_clr)
);

// File: tb/sim_io_irq_unit.sv
`timescale 1ns/1ps
// Bench for io_irq_unit: decode vector table, then directed flag and interrupt tests.
module sim_io_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] t_step = '0;
    logic [15:0] instr = '0;
    logic [7:0] acc_lo = '0;
    logic       dev_in_valid = 1'b0;
    logic [7:0] dev_in_data = '0;
    logic       dev_out_ready = 1'b0;
    logic       dev_in_ready, dev_out_valid, acc_lo_ld, pc_inc, pc_clr;
    logic       ar_clr, tr_ld_pc, mem_wr, sc_clr, irq_cycle;
    logic [7:0] dev_out_data, acc_lo_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    io_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .t_step(t_step), .instr(instr), .acc_lo(acc_lo),
        .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
        .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready),
        .acc_lo_ld(acc_lo_ld), .acc_lo_data(acc_lo_data), .pc_inc(pc_inc), .pc_clr(pc_clr),
        .ar_clr(ar_clr), .tr_ld_pc(tr_ld_pc), .mem_wr(mem_wr), .sc_clr(sc_clr),
        .irq_cycle(irq_cycle)
    );

    // Fields: t_step, instr, expected {sc_clr, pc_inc, acc_lo_ld}; state is post-reset.
    localparam int NV = 8;
    localparam logic [22:0] VEC [NV] = '{
        {4'd3, 16'hF800, 3'b101},   // R3, R7 input
        {4'd3, 16'hF200, 3'b100},   // R5 SKI with input flag 0
        {4'd3, 16'hF100, 3'b110},   // R5 SKO with output flag 1
        {4'd3, 16'hF300, 3'b110},   // R5 both skip bits
        {4'd2, 16'hF100, 3'b000},   // R8 wrong step
        {4'd4, 16'hF800, 3'b000},   // R8 late step
        {4'd3, 16'h7100, 3'b000},   // R7 I=0
        {4'd3, 16'hE100, 3'b000}    // R7 other opcode with I=1
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick();
        rst_n = 1'b1;
        #1;
        chk("R1 in_ready", dev_in_ready, 1);
        chk("R1 out_valid", dev_out_valid, 0);
        chk("R1 irq_cycle", irq_cycle, 0);

        for (int i = 0; i < NV; i++) begin
            t_step = VEC[i][22:19];
            instr  = VEC[i][18:3];
            #1;
            chk("R7/R8 vec sc_clr", sc_clr, VEC[i][2]);
            chk("R5/R8 vec pc_inc", pc_inc, VEC[i][1]);
            chk("R3/R8 vec acc_ld", acc_lo_ld, VEC[i][0]);
            tick();
        end
        t_step = 4'd0; instr = 16'h0000;

        // R2 device write
        dev_in_valid = 1'b1; dev_in_data = 8'hA5;
        tick();
        dev_in_valid = 1'b0;
        chk("R2 in_ready after write", dev_in_ready, 0);

        // R5 SKI with input flag set
        t_step = 4'd3; instr = 16'hF200; #1;
        chk("R5 SKI skip", pc_inc, 1);

        // R3 input into accumulator low byte
        instr = 16'hF800; #1;
        chk("R3 acc_lo_ld", acc_lo_ld, 1);
        chk("R3 acc_lo_data", acc_lo_data, 8'hA5);
        tick();
        t_step = 4'd0; instr = 16'h0000; #1;
        chk("R3 flag cleared", dev_in_ready, 1);

        // R4 output
        t_step = 4'd3; instr = 16'hF400; acc_lo = 8'h3C;
        tick();
        instr = 16'hF100; #1;
        chk("R4 out_valid", dev_out_valid, 1);
        chk("R4 out_data", dev_out_data, 8'h3C);
        chk("R5 SKO no skip", pc_inc, 0);
        t_step = 4'd0; instr = 16'h0000; dev_out_ready = 1'b1;
        tick();
        dev_out_ready = 1'b0;
        chk("R4 device read", dev_out_valid, 0);

        // R6 ION+IOF together: off wins, no interrupt even with output flag set
        t_step = 4'd3; instr = 16'hF0C0;
        tick();
        t_step = 4'd4; instr = 16'h0000;
        tick();
        chk("R6 off wins", irq_cycle, 0);

        // R6 ION, then R9 window: steps 0..2 never raise the flag
        t_step = 4'd3; instr = 16'hF080;
        tick();
        instr = 16'h0000;
        for (int s = 0; s < 3; s++) begin
            t_step = 4'(s);
            tick();
            chk("R9 no raise in fetch", irq_cycle, 0);
        end
        t_step = 4'd3;
        tick();
        chk("R6/R9 irq raised", irq_cycle, 1);

        // R10 entry sequence
        t_step = 4'd0; #1;
        chk("R10 T0 ar_clr", ar_clr, 1);
        chk("R10 T0 tr_ld_pc", tr_ld_pc, 1);
        chk("R10 T0 mem_wr", mem_wr, 0);
        tick();
        t_step = 4'd1; #1;
        chk("R10 T1 mem_wr", mem_wr, 1);
        chk("R10 T1 pc_clr", pc_clr, 1);
        tick();
        t_step = 4'd2; #1;
        chk("R10 T2 pc_inc", pc_inc, 1);
        chk("R10 T2 sc_clr", sc_clr, 1);
        tick();
        chk("R11 irq cleared", irq_cycle, 0);
        t_step = 4'd3;
        tick();
        chk("R11 enable cleared", irq_cycle, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule